// File: doc/BRIEF.md
# PWM Divider Parameter Search Engine

This block picks the settings for a two-stage backlight PWM divider. The first stage is an 8-bit pre-divider F. The second stage is a power-of-two counter of 2^Pn steps. The caller supplies a target product FxP, which is the base clock divided by the wanted PWM frequency, along with the lowest and highest Pn the panel allows. The engine looks for the largest Pn for which the rounded pre-divider gives an actual product F·2^Pn within ±25 % of the target. A larger Pn gives finer brightness steps, so the largest passing Pn is the one reported.

A one-cycle start pulse captures the request. The engine first rejects requests whose tolerance window cannot be reached even at the extreme settings. It then evaluates one Pn per clock, counting down from the maximum. When it finishes it raises done and reports one of four outcomes: success, panel default (the target was zero), out of range, or no fit. The results stay in place until the next start.

Top module: `pwm_div_search`

## Requirements
- R1: After reset, done_o, status_o, pn_o, f_o and bright_o are all zero.
- R2: A target of zero does no search. It ends with status_o = 1 (panel default) and pn_o, f_o and bright_o at zero. done_o rises on the second rising edge counted from the edge that samples start_i.
- R3: The tolerance window is lo = floor((3·FxP+2)/4) and hi = floor((5·FxP+2)/4), so both bounds round to nearest with halves rounding up. Both bounds are inclusive.
- R4: A nonzero request is rejected with status_o = 2 (out of range) and pn_o, f_o and bright_o at zero, if any of these holds: lo < 2^Pn_min, or 255·2^Pn_max < hi, or Pn_min > Pn_max. done_o rises on the second edge, as in R2.
- R5: For a candidate Pn, F = floor((FxP + 2^(Pn−1)) / 2^Pn), or F = FxP when Pn = 0. F is then clamped to the range 1..255. The candidate passes when lo ≤ F·2^Pn ≤ hi.
- R6: The search starts at Pn_max and lowers Pn by one per clock. It stops at the first candidate that passes and reports status_o = 0 (success) with that Pn and its F. done_o rises on edge 2+n, where n is the number of candidates evaluated.
- R7: On success, bright_o = 2^pn_o − 1. On every other outcome, bright_o = 0.
- R8: If no candidate down to Pn_min passes, status_o = 3 (no fit). pn_o = Pn_min and f_o holds the F computed for Pn_min.
- R9: A start pulse clears done_o on the next edge and relaunches the engine from any state. While start_i stays low, done_o and all results hold steady, even if the request inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse that captures the request and launches the engine |
| fxp_i | input | FXP_W (24) | Target divider product FxP |
| pn_min_i | input | PN_W (5) | Lowest allowed Pn |
| pn_max_i | input | PN_W (5) | Highest allowed Pn |
| done_o | output | 1 | Result valid; held until the next start |
| status_o | output | 2 | 0 success, 1 panel default, 2 out of range, 3 no fit |
| pn_o | output | PN_W (5) | Chosen Pn |
| f_o | output | F_W (8) | Chosen pre-divider F |
| bright_o | output | 2^PN_W (32) | Maximum brightness code |

## Verification
Counting the edge that samples start_i as the first, a zero target or a rejected request completes on the second edge. A search that evaluates n candidates completes on edge 2+n. The bench drives inputs on falling edges and counts edges up to the first falling edge where done_o is high. It compares that count with the latency expected for each vector, and it also checks that done_o is low one edge after start. Each result field is compared only once done_o is seen high. A separate hold test changes the inputs without a start and checks that the outputs do not move.

// File: rtl/pwm_div_pkg.sv
package pwm_div_pkg;

  typedef enum logic [1:0] {
    ST_OK      = 2'd0,
    ST_DEFAULT = 2'd1,
    ST_RANGE   = 2'd2,
    ST_NOFIT   = 2'd3
  } status_e;

  typedef enum logic [1:0] {
    S_IDLE   = 2'd0,
    S_CHECK  = 2'd1,
    S_SEARCH = 2'd2
  } state_e;

endpackage

// File: rtl/pwm_div_window.sv
module pwm_div_window #(
  parameter int FXP_W = 24,
  parameter int PN_W  = 5,
  parameter int F_W   = 8,
  parameter int CMP_W = F_W + (1 << PN_W)
) (
  input  logic [FXP_W-1:0] fxp_i,
  input  logic [PN_W-1:0]  pn_min_i,
  input  logic [PN_W-1:0]  pn_max_i,
  output logic [CMP_W-1:0] lo_o,
  output logic [CMP_W-1:0] hi_o,
  output logic             reject_o
);

  localparam int F_MAX = (1 << F_W) - 1;

  logic [CMP_W-1:0] fx;
  logic [CMP_W-1:0] floor_lim;
  logic [CMP_W-1:0] ceil_lim;

  always_comb begin
    fx        = CMP_W'(fxp_i);
    // round-to-nearest of 3/4 and 5/4
    lo_o      = (fx * CMP_W'(3) + CMP_W'(2)) >> 2;
    hi_o      = (fx * CMP_W'(5) + CMP_W'(2)) >> 2;
    floor_lim = CMP_W'(1) << pn_min_i;
    ceil_lim  = CMP_W'(F_MAX) << pn_max_i;
    reject_o  = (lo_o < floor_lim) || (ceil_lim < hi_o) || (pn_min_i > pn_max_i);
  end

endmodule

// File: rtl/pwm_div_eval.sv
module pwm_div_eval #(
  parameter int FXP_W = 24,
  parameter int PN_W  = 5,
  parameter int F_W   = 8,
  parameter int CMP_W = F_W + (1 << PN_W)
) (
  input  logic [FXP_W-1:0] fxp_i,
  input  logic [PN_W-1:0]  pn_i,
  input  logic [CMP_W-1:0] lo_i,
  input  logic [CMP_W-1:0] hi_i,
  output logic [F_W-1:0]   f_o,
  output logic [CMP_W-1:0] actual_o,
  output logic             pass_o
);

  localparam int F_MAX = (1 << F_W) - 1;

  logic [CMP_W-1:0] half;
  logic [CMP_W-1:0] rnd;

  always_comb begin
    half = (pn_i == '0) ? '0 : (CMP_W'(1) << (pn_i - PN_W'(1)));
    rnd  = (CMP_W'(fxp_i) + half) >> pn_i;
    if (rnd == '0)                  f_o = F_W'(1);
    else if (rnd > CMP_W'(F_MAX))   f_o = F_W'(F_MAX);
    else                            f_o = rnd[F_W-1:0];
    actual_o = CMP_W'(f_o) << pn_i;
    pass_o   = (actual_o >= lo_i) && (actual_o <= hi_i);
  end

endmodule

// File: rtl/pwm_div_search.sv
module pwm_div_search
  import pwm_div_pkg::*;
#(
  parameter int FXP_W = 24,
  parameter int PN_W  = 5,
  parameter int F_W   = 8,
  localparam int BRT_W = 1 << PN_W,
  localparam int CMP_W = F_W + BRT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [FXP_W-1:0] fxp_i,
  input  logic [PN_W-1:0]  pn_min_i,
  input  logic [PN_W-1:0]  pn_max_i,
  output logic             done_o,
  output logic [1:0]       status_o,
  output logic [PN_W-1:0]  pn_o,
  output logic [F_W-1:0]   f_o,
  output logic [BRT_W-1:0] bright_o
);

  state_e           state_q;
  logic [FXP_W-1:0] fxp_q;
  logic [PN_W-1:0]  pmin_q;
  logic [PN_W-1:0]  pmax_q;
  logic [PN_W-1:0]  pn_cur_q;

  logic [CMP_W-1:0] win_lo;
  logic [CMP_W-1:0] win_hi;
  logic             reject;
  logic [F_W-1:0]   cand_f;
  logic [CMP_W-1:0] cand_actual;
  logic             cand_pass;

  pwm_div_window #(
    .FXP_W(FXP_W), .PN_W(PN_W), .F_W(F_W), .CMP_W(CMP_W)
  ) u_window (
    .fxp_i    (fxp_q),
    .pn_min_i (pmin_q),
    .pn_max_i (pmax_q),
    .lo_o     (win_lo),
    .hi_o     (win_hi),
    .reject_o (reject)
  );

  pwm_div_eval #(
    .FXP_W(FXP_W), .PN_W(PN_W), .F_W(F_W), .CMP_W(CMP_W)
  ) u_eval (
    .fxp_i    (fxp_q),
    .pn_i     (pn_cur_q),
    .lo_i     (win_lo),
    .hi_i     (win_hi),
    .f_o      (cand_f),
    .actual_o (cand_actual),
    .pass_o   (cand_pass)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      fxp_q    <= '0;
      pmin_q   <= '0;
      pmax_q   <= '0;
      pn_cur_q <= '0;
      done_o   <= 1'b0;
      status_o <= ST_OK;
      pn_o     <= '0;
      f_o      <= '0;
      bright_o <= '0;
    end else if (start_i) begin
      fxp_q   <= fxp_i;
      pmin_q  <= pn_min_i;
      pmax_q  <= pn_max_i;
      done_o  <= 1'b0;
      state_q <= S_CHECK;
    end else begin
      unique case (state_q)
        S_CHECK: begin
          if (fxp_q == '0 || reject) begin
            done_o   <= 1'b1;
            status_o <= (fxp_q == '0) ? ST_DEFAULT : ST_RANGE;
            pn_o     <= '0;
            f_o      <= '0;
            bright_o <= '0;
            state_q  <= S_IDLE;
          end else begin
            pn_cur_q <= pmax_q;
            state_q  <= S_SEARCH;
          end
        end
        S_SEARCH: begin
          if (cand_pass) begin
            done_o   <= 1'b1;
            status_o <= ST_OK;
            pn_o     <= pn_cur_q;
            f_o      <= cand_f;
            bright_o <= (BRT_W'(1) << pn_cur_q) - BRT_W'(1);
            state_q  <= S_IDLE;
          end else if (pn_cur_q == pmin_q) begin
            done_o   <= 1'b1;
            status_o <= ST_NOFIT;
            pn_o     <= pn_cur_q;
            f_o      <= cand_f;
            bright_o <= '0;
            state_q  <= S_IDLE;
          end else begin
            pn_cur_q <= pn_cur_q - PN_W'(1);
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R6: each search step lowers Pn by one
  p_search_desc_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_SEARCH && $past(state_q) == S_SEARCH)
      |-> (pn_cur_q == $past(pn_cur_q) - PN_W'(1)));

  p_start_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !done_o);

  p_done_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(status_o) && $stable(pn_o) && $stable(f_o)));

  p_ok_window_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && status_o == ST_OK)
      |-> ((CMP_W'(f_o) << pn_o) >= win_lo && (CMP_W'(f_o) << pn_o) <= win_hi
           && pn_o >= pmin_q && pn_o <= pmax_q));

  p_ok_bright_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && status_o == ST_OK) |-> ($countones(bright_o) == 32'(pn_o) && bright_o[0] == (pn_o != '0)));

  p_nofit_floor_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && status_o == ST_NOFIT) |-> (pn_o == pmin_q && bright_o == '0));

  p_default_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && status_o == ST_DEFAULT) |-> (fxp_q == '0 && bright_o == '0 && f_o == '0));

endmodule

// File: tb/pwm_div_search_bench.sv
`timescale 1ns/1ps
module pwm_div_search_bench;

  typedef struct packed {
    logic [23:0] fxp;
    logic [4:0]  pmin;
    logic [4:0]  pmax;
    logic [1:0]  st;
    logic [4:0]  pn;
    logic [7:0]  f;
    logic [31:0] br;
    logic [7:0]  lat;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{24'd0,      5'd0, 5'd0,  2'd1, 5'd0,  8'd0,  32'd0,    8'd2},
    '{24'd100,    5'd3, 5'd3,  2'd0, 5'd3,  8'd13, 32'd7,    8'd3},
    '{24'd23,     5'd4, 5'd4,  2'd3, 5'd4,  8'd1,  32'd0,    8'd3},
    '{24'd135000, 5'd2, 5'd11, 2'd0, 5'd11, 8'd66, 32'd2047, 8'd3},
    '{24'd200,    5'd2, 5'd7,  2'd0, 5'd6,  8'd3,  32'd63,   8'd4},
    '{24'd23,     5'd2, 5'd5,  2'd0, 5'd3,  8'd3,  32'd7,    8'd5},
    '{24'd10,     5'd4, 5'd6,  2'd2, 5'd0,  8'd0,  32'd0,    8'd2},
    '{24'd100000, 5'd0, 5'd5,  2'd2, 5'd0,  8'd0,  32'd0,    8'd2},
    '{24'd100,    5'd5, 5'd3,  2'd2, 5'd0,  8'd0,  32'd0,    8'd2},
    '{24'd23,     5'd4, 5'd5,  2'd3, 5'd4,  8'd1,  32'd0,    8'd4},
    '{24'd20,     5'd2, 5'd6,  2'd0, 5'd4,  8'd1,  32'd15,   8'd5}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] fxp = '0;
  logic [4:0]  pmin = '0;
  logic [4:0]  pmax = '0;
  logic        done;
  logic [1:0]  status;
  logic [4:0]  pn;
  logic [7:0]  f;
  logic [31:0] bright;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  pwm_div_search u_pwm_div_search (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .start_i  (start),
    .fxp_i    (fxp),
    .pn_min_i (pmin),
    .pn_max_i (pmax),
    .done_o   (done),
    .status_o (status),
    .pn_o     (pn),
    .f_o      (f),
    .bright_o (bright)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [1:0] st);
    case (st)
      2'd0: return "R6";
      2'd1: return "R2";
      2'd2: return "R4";
      default: return "R8";
    endcase
  endfunction

  task automatic launch(input vec_t v);
    @(negedge clk);
    fxp = v.fxp; pmin = v.pmin; pmax = v.pmax; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_check(input vec_t v, input string tag);
    int lat = 1;
    chk("R9", "done low after start", longint'(done), 0);
    while (!done && lat < 60) begin
      @(negedge clk);
      lat++;
    end
    chk("R6", "latency", lat, longint'(v.lat));
    chk(tag, "status", longint'(status), longint'(v.st));
    chk(tag, "pn", longint'(pn), longint'(v.pn));
    chk(tag, "f", longint'(f), longint'(v.f));
    chk("R7", "bright", longint'(bright), longint'(v.br));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    vec_t v;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "done", longint'(done), 0);
    chk("R1", "status", longint'(status), 0);
    chk("R1", "pn", longint'(pn), 0);
    chk("R1", "f", longint'(f), 0);
    chk("R1", "bright", longint'(bright), 0);
    rst_n = 1'b1;

    // R5 candidate rounding/clamp exercised across the table
    for (int i = 0; i < NV; i++) begin
      launch(VECS[i]);
      wait_check(VECS[i], tag_of(VECS[i].st));
    end

    // R3 window rounding boundaries
    v = '{24'd10, 5'd3, 5'd3, 2'd0, 5'd3, 8'd1, 32'd7, 8'd3};
    launch(v); wait_check(v, "R3");
    v = '{24'd204, 5'd0, 5'd0, 2'd0, 5'd0, 8'd204, 32'd0, 8'd3};
    launch(v); wait_check(v, "R3");
    v = '{24'd205, 5'd0, 5'd0, 2'd2, 5'd0, 8'd0, 32'd0, 8'd2};
    launch(v); wait_check(v, "R3");

    // R9 hold: inputs change without start, outputs stay
    v = VECS[4];
    launch(v); wait_check(v, "R5");
    fxp = 24'd23; pmin = 5'd0; pmax = 5'd9;
    repeat (6) @(negedge clk);
    chk("R9", "held done", longint'(done), 1);
    chk("R9", "held status", longint'(status), 0);
    chk("R9", "held pn", longint'(pn), 6);
    chk("R9", "held f", longint'(f), 3);
    chk("R9", "held bright", longint'(bright), 63);

    // R9 restart in mid-search
    launch(VECS[5]);
    @(negedge clk);
    chk("R9", "busy before restart", longint'(done), 0);
    launch(VECS[1]);
    wait_check(VECS[1], "R9");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule